// File: doc/BRIEF.md
# SMBus Word-Register Slave

This block is a bus slave for a two-wire management bus. It serves a small map of 16-bit registers through the Write-Word and Read-Word transactions. It runs on a fast system clock and takes SCL and SDA inputs that are already synchronized to that clock. It finds bus edges, start, repeated start and stop by comparing each input with its value one clock earlier. It drives SDA only through an open-drain pull-down enable.

A transaction opens with an address byte. Next comes a command byte, which loads the register pointer. A write then moves two data bytes, low byte first. A read instead issues a repeated start and a read address, and the slave returns the pointed word, low byte first. The map holds three setting registers, each with only some bits implemented, and two fixed identification words. The three setting values are brought out on ports for the logic behind the block.

Top module: `smbw_top`

## Requirements
- R1: The slave answers only the 7-bit address 0b0001001, which gives address byte 0x12 for a write and 0x13 for a read (bit 0 is R/W, with 1 meaning read). A byte with any other address gets no acknowledge. All later bytes, up to the next start, are ignored and get no acknowledge.
- R2: The slave acknowledges by pulling SDA low during the ninth clock after each of these bytes: a matching address byte, the command byte, and both write data bytes. It releases SDA after the falling edge of that ninth clock.
- R3: A write delivers data low byte then high byte, most significant bit first. The addressed register is updated in one step, only after the ninth clock of the high byte. Bits outside a register's implemented field are dropped.
- R4: After a repeated start and address 0x13, the slave sends the pointed word low byte first, most significant bit first. It moves on to the high byte only if the master acknowledged the low byte. After the master's no-acknowledge that ends the high byte, SDA stays released.
- R5: Command 0x14 selects the charge-current setting. It implements bits [12:7] only and resets to 0x0000.
- R6: Command 0x15 selects the charge-voltage setting. It implements bits [14:4] only and resets to 0x0000.
- R7: Command 0x3F selects the input-current setting. It implements bits [12:7] only and resets to 0x0080.
- R8: Command 0xFE reads 0x0049 and command 0xFF reads 0x0001. A write to either is acknowledged and has no effect.
- R9: A read of any other command value returns 0x0000. A write to such a value is acknowledged and changes no register.
- R10: A stop, or a repeated start, that arrives before the high data byte has been acknowledged discards the write. The register keeps its previous value.
- R11: The slave begins pulling SDA low only while SCL is low, so its drive never forms a start or stop condition. It never starts a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level (wired-AND of all drivers) |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| chargeCurrent | output | 16 | Charge-current setting word |
| chargeVoltage | output | 16 | Charge-voltage setting word |
| inputCurrent | output | 16 | Input-current setting word |

## Verification
The assertions take several things for granted about the inputs. SCL and SDA arrive already synchronized and free of glitches. SDA changes while SCL is high only to form a start or a stop. Every SCL level lasts for several system clocks, so an edge and the slave's response one clock later never fall into the same phase. The bench's bit-banging master holds each SCL phase for four clocks and changes its own data only in the low phase. Its SDA is modelled as a wired-AND with the slave's pull-down, so the slave sees exactly what an open-drain line would show.

// File: rtl/smbw_pkg.sv
package smbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WLO,
    ST_WHI,
    ST_READ,
    ST_SKIP
  } busState_t;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic ptrLoad;  // command byte complete
    logic loLoad;   // low data byte complete
    logic commit;   // high data byte acknowledged
  } dpStrobe_t;

  localparam logic [7:0]  CMD_CUR   = 8'h14;
  localparam logic [7:0]  CMD_VOLT  = 8'h15;
  localparam logic [7:0]  CMD_INCUR = 8'h3F;
  localparam logic [7:0]  CMD_MFR   = 8'hFE;
  localparam logic [7:0]  CMD_DEV   = 8'hFF;

  localparam logic [15:0] MASK_CUR   = 16'h1F80;
  localparam logic [15:0] MASK_VOLT  = 16'h7FF0;
  localparam logic [15:0] MASK_INCUR = 16'h1F80;

endpackage

// File: rtl/smbw_ctrl.sv
module smbw_ctrl
  import smbw_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h09,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2*BYTE_W-1:0] rdWord,
  output dpStrobe_t         strb,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(BYTE_W + 1);

  busState_t         state;
  logic              sclPrev, sdaPrev;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] txSh;
  logic              rwBit, rdHi, mstAck;

  logic sclRise, sclFall, startDet, stopDet, addrHit;

  assign sclRise  = sclIn & ~sclPrev;
  assign sclFall  = ~sclIn & sclPrev;
  assign startDet = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopDet  = sclIn & sclPrev & ~sdaPrev & sdaIn;
  assign addrHit  = (shReg[BYTE_W-1:1] == SLV_ADDR);
  assign rxByte   = shReg;

  always_comb begin
    strb = '0;
    if (!startDet && !stopDet && sclFall) begin
      if (bitCnt == ACK_CNT) begin
        strb.ptrLoad = (state == ST_CMD);
        strb.loLoad  = (state == ST_WLO);
      end
      if (bitCnt == END_CNT) strb.commit = (state == ST_WHI);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      bitCnt  <= '0;
      shReg   <= '0;
      txSh    <= '0;
      rwBit   <= 1'b0;
      rdHi    <= 1'b0;
      mstAck  <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (state inside {ST_ADDR, ST_CMD, ST_WLO, ST_WHI}) begin
        if (sclRise) begin
          if (bitCnt < ACK_CNT) shReg <= {shReg[BYTE_W-2:0], sdaIn};
          bitCnt <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (bitCnt == ACK_CNT) begin
            if (state == ST_ADDR && !addrHit) begin
              state <= ST_SKIP;
            end else begin
              sdaOe <= 1'b1;
              if (state == ST_ADDR) rwBit <= shReg[0];
            end
          end else if (bitCnt == END_CNT) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            case (state)
              ST_ADDR: begin
                if (rwBit) begin
                  state <= ST_READ;
                  txSh  <= rdWord[BYTE_W-1:0];
                  sdaOe <= ~rdWord[BYTE_W-1];
                  rdHi  <= 1'b0;
                end else begin
                  state <= ST_CMD;
                end
              end
              ST_CMD:  state <= ST_WLO;
              ST_WLO:  state <= ST_WHI;
              default: state <= ST_SKIP;
            endcase
          end
        end
      end else if (state == ST_READ) begin
        if (sclRise) begin
          if (bitCnt == ACK_CNT) mstAck <= ~sdaIn;
          bitCnt <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (bitCnt < ACK_CNT) begin
            sdaOe <= ~txSh[BYTE_W-2];
            txSh  <= {txSh[BYTE_W-2:0], 1'b0};
          end else if (bitCnt == ACK_CNT) begin
            sdaOe <= 1'b0;
          end else begin
            bitCnt <= '0;
            if (mstAck && !rdHi) begin
              rdHi  <= 1'b1;
              txSh  <= rdWord[2*BYTE_W-1:BYTE_W];
              sdaOe <= ~rdWord[2*BYTE_W-1];
            end else begin
              state <= ST_SKIP;
            end
          end
        end
      end
    end
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && !$past(sdaOe)) |-> !sclIn); // R11
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaOe && state == ST_IDLE)); // R10
  AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(sdaOe)); // R3

endmodule

// File: rtl/smbw_regs.sv
module smbw_regs
  import smbw_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter logic [15:0] MFR_ID  = 16'h0049,
  parameter logic [15:0] DEV_ID  = 16'h0001,
  parameter logic [15:0] INCUR_RST = 16'h0080
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [BYTE_W-1:0]   rxByte,
  output logic [2*BYTE_W-1:0] rdWord,
  output logic [2*BYTE_W-1:0] curReg,
  output logic [2*BYTE_W-1:0] voltReg,
  output logic [2*BYTE_W-1:0] inCurReg
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] loLatch;
  logic [WORD_W-1:0] wrWord;

  assign wrWord = {rxByte, loLatch};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      loLatch  <= '0;
      curReg   <= '0;
      voltReg  <= '0;
      inCurReg <= INCUR_RST & MASK_INCUR;
    end else begin
      if (strb.ptrLoad) ptr <= rxByte;
      if (strb.loLoad)  loLatch <= rxByte;
      if (strb.commit) begin
        case (ptr)
          CMD_CUR:   curReg   <= wrWord & MASK_CUR;
          CMD_VOLT:  voltReg  <= wrWord & MASK_VOLT;
          CMD_INCUR: inCurReg <= wrWord & MASK_INCUR;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (ptr)
      CMD_CUR:   rdWord = curReg;
      CMD_VOLT:  rdWord = voltReg;
      CMD_INCUR: rdWord = inCurReg;
      CMD_MFR:   rdWord = MFR_ID;
      CMD_DEV:   rdWord = DEV_ID;
      default:   rdWord = '0;
    endcase
  end

  AST_CUR_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curReg) |-> ($past(strb.commit) && $past(ptr) == CMD_CUR)); // R3
  AST_VOLT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(voltReg) |-> ($past(strb.commit) && $past(ptr) == CMD_VOLT)); // R6
  AST_INCUR_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inCurReg) |-> ($past(strb.commit) && $past(ptr) == CMD_INCUR)); // R7
  AST_PTR_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> $past(strb.ptrLoad)); // R9

endmodule

// File: rtl/smbw_top.sv
module smbw_top
  import smbw_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'h09,
  parameter logic [15:0] MFR_ID   = 16'h0049,
  parameter logic [15:0] DEV_ID   = 16'h0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output logic [15:0] chargeCurrent,
  output logic [15:0] chargeVoltage,
  output logic [15:0] inputCurrent
);

  localparam int BYTE_W = 8;

  dpStrobe_t           strb;
  logic [BYTE_W-1:0]   rxByte;
  logic [2*BYTE_W-1:0] rdWord;

  smbw_ctrl #(.SLV_ADDR(SLV_ADDR), .BYTE_W(BYTE_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rdWord (rdWord),
    .strb   (strb),
    .rxByte (rxByte),
    .sdaOe  (sdaOe)
  );

  smbw_regs #(.BYTE_W(BYTE_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxByte   (rxByte),
    .rdWord   (rdWord),
    .curReg   (chargeCurrent),
    .voltReg  (chargeVoltage),
    .inCurReg (inputCurrent)
  );

endmodule

// File: tb/smbw_top_tb.sv
module smbw_top_tb;

  localparam int Q = 4;

  typedef struct {
    string       req;
    logic [15:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mPull = 1'b0;
  logic sdaLine;
  logic sdaOe;
  logic [15:0] chargeCurrent, chargeVoltage, inputCurrent;

  int total = 0;
  int bad = 0;
  int illegalDrive = 0;
  bit done = 0;

  item_t expQ[$];
  logic [15:0] obsQ[$];

  always #2 clk = ~clk;

  assign sdaLine = ~(mPull | sdaOe);

  smbw_top u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .sclIn         (scl),
    .sdaIn         (sdaLine),
    .sdaOe         (sdaOe),
    .chargeCurrent (chargeCurrent),
    .chargeVoltage (chargeVoltage),
    .inputCurrent  (inputCurrent)
  );

  // R11 watcher: pull-down may only start while SCL is low
  logic oePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe && !oePrev && scl) illegalDrive++;
    oePrev <= sdaOe;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    while (obsQ.size() > 0) begin
      logic [15:0] got;
      item_t e;
      got = obsQ.pop_front();
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL none: actual=%h expected=<empty>", got);
      end else begin
        e = expQ.pop_front();
        if (got !== e.val) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", e.req, got, e.val);
        end
      end
    end
  end

  task automatic expect_(input string req, input logic [15:0] v);
    expQ.push_back('{req, v});
  endtask

  task automatic hw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    mPull = 1'b0; hw(1);
    scl = 1'b1;   hw(1);
    mPull = 1'b1; hw(1);
    scl = 1'b0;   hw(1);
  endtask

  task automatic busStop();
    mPull = 1'b1; hw(1);
    scl = 1'b1;   hw(1);
    mPull = 1'b0; hw(1);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackBit);
    for (int i = 7; i >= 0; i--) begin
      mPull = ~b[i]; hw(1);
      scl = 1'b1;    hw(2);
      scl = 1'b0;    hw(1);
    end
    mPull = 1'b0; hw(1);
    scl = 1'b1;   hw(1);
    ackBit = sdaLine;
    hw(1);
    scl = 1'b0;   hw(1);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    mPull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hw(1);
      scl = 1'b1; hw(1);
      b[i] = sdaLine;
      hw(1);
      scl = 1'b0;
    end
    mPull = giveAck; hw(1);
    scl = 1'b1; hw(2);
    scl = 1'b0; hw(1);
    mPull = 1'b0;
  endtask

  // full Write-Word; every slave acknowledge is a scored item
  task automatic writeWord(input logic [7:0] cmd, input logic [15:0] d);
    logic a;
    expect_("R1", 16'h0); writeByte(8'h12, a);      obsQ.push_back({15'h0, a});
    expect_("R2", 16'h0); writeByte(cmd, a);        obsQ.push_back({15'h0, a});
    expect_("R2", 16'h0); writeByte(d[7:0], a);     obsQ.push_back({15'h0, a});
    expect_("R2", 16'h0); writeByte(d[15:8], a);    obsQ.push_back({15'h0, a});
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [15:0] d);
    busStart();
    writeWord(cmd, d);
    busStop();
  endtask

  task automatic doRead(input logic [7:0] cmd, input logic [15:0] expV, input string req);
    logic a;
    logic [7:0] lo, hi;
    busStart();
    writeByte(8'h12, a);
    writeByte(cmd, a);
    busStart();
    expect_("R4", 16'h0); writeByte(8'h13, a); obsQ.push_back({15'h0, a});
    readByte(1'b1, lo);
    readByte(1'b0, hi);
    hw(1);
    expect_("R4", 16'h0); obsQ.push_back({15'h0, sdaOe});
    busStop();
    expect_(req, expV); obsQ.push_back({hi, lo});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] lo, hi;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    expect_("R11", 16'h0);    obsQ.push_back({15'h0, sdaOe});
    expect_("R5", 16'h0000);  obsQ.push_back(chargeCurrent);
    expect_("R6", 16'h0000);  obsQ.push_back(chargeVoltage);
    expect_("R7", 16'h0080);  obsQ.push_back(inputCurrent);

    // identification and reset values over the bus
    doRead(8'hFE, 16'h0049, "R8");
    doRead(8'hFF, 16'h0001, "R8");
    doRead(8'h3F, 16'h0080, "R7");
    doRead(8'h14, 16'h0000, "R5");
    doRead(8'h15, 16'h0000, "R6");

    // masked writes
    doWrite(8'h14, 16'hFFFF);
    doRead(8'h14, 16'h1F80, "R5");
    expect_("R3", 16'h1F80); obsQ.push_back(chargeCurrent);
    doWrite(8'h15, 16'h1234);
    doRead(8'h15, 16'h1230, "R6");
    doWrite(8'h15, 16'hFFFF);
    expect_("R6", 16'h7FF0); obsQ.push_back(chargeVoltage);
    doWrite(8'h3F, 16'h0A55);
    doRead(8'h3F, 16'h0A00, "R7");
    expect_("R3", 16'h0A00); obsQ.push_back(inputCurrent);

    // read-only and unmapped
    doWrite(8'hFE, 16'h1234);
    doRead(8'hFE, 16'h0049, "R8");
    doWrite(8'h20, 16'hBEEF);
    doRead(8'h20, 16'h0000, "R9");
    doRead(8'h14, 16'h1F80, "R9");
    expect_("R9", 16'h7FF0); obsQ.push_back(chargeVoltage);

    // foreign address: no acknowledge anywhere, nothing written
    busStart();
    expect_("R1", 16'h1); writeByte(8'h14, a); obsQ.push_back({15'h0, a});
    expect_("R1", 16'h1); writeByte(8'h14, a); obsQ.push_back({15'h0, a});
    expect_("R1", 16'h1); writeByte(8'h00, a); obsQ.push_back({15'h0, a});
    expect_("R1", 16'h1); writeByte(8'h00, a); obsQ.push_back({15'h0, a});
    busStop();
    busStart();
    expect_("R1", 16'h1); writeByte(8'h93, a); obsQ.push_back({15'h0, a});
    busStop();
    doRead(8'h14, 16'h1F80, "R1");

    // abort by stop after low byte
    busStart();
    writeByte(8'h12, a); writeByte(8'h14, a); writeByte(8'h00, a);
    busStop();
    doRead(8'h14, 16'h1F80, "R10");
    expect_("R10", 16'h1F80); obsQ.push_back(chargeCurrent);

    // abort by repeated start after low byte, then read same pointer
    busStart();
    writeByte(8'h12, a); writeByte(8'h15, a); writeByte(8'h00, a);
    busStart();
    writeByte(8'h13, a);
    readByte(1'b1, lo);
    readByte(1'b0, hi);
    busStop();
    expect_("R10", 16'h7FF0); obsQ.push_back({hi, lo});

    // R11 summary of the drive watcher
    expect_("R11", 16'h0); obsQ.push_back(16'(illegalDrive));

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule